// File: doc/BRIEF.md
# Halfband Rate-Change Filter

This block is a fixed-coefficient 67-tap halfband FIR that changes the sample rate of a real 16-bit stream by a factor of two in either direction. In decimation it takes one sample per accepted strobe and returns one filtered sample for every second input. In interpolation it returns two filtered samples for each input, on two consecutive cycles. A two-bit mode code picks the direction and which of two input buses feeds the filter.

The work is split into two polyphase branches. Of the even-offset taps only the centre is non-zero, and it is exactly one half, so that branch is just a scaled, delayed sample. The 34 odd-offset taps form 17 symmetric pairs, and each pair's samples are added before one multiply. A three-bit control sets where the result is rounded, which is also the output gain. A format bit selects two's-complement or offset-binary output. A sync strobe forces the decimation phase.

Top module: `hb_filter`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_data` is 0 until the first accepted input.
- R2: Filter taps h[0..66] have h[33] = 32768 and h[33-(2j+1)] = h[33+(2j+1)] = c[j] for j = 0..16, where c = 20750, -6850, 4000, -2700, 1950, -1450, 1080, -800, 590, -430, 300, -205, 135, -85, 50, -26, 10, all in units of 2^-16. Every other tap is zero. In decimation the accumulator is the sum of h[k]·x[n-k], where x[n] is the sample being accepted and samples before reset count as zero.
- R3: With mode bit 0 clear, accepted samples alternate between producing an output and producing none. An output appears with `out_valid` high on the cycle after its sample is accepted.
- R4: A sample accepted with `sync` high in decimation always produces an output. The sample accepted after it produces none.
- R5: With mode bit 0 set, each accepted sample x[m] gives two outputs on the next two cycles. The first uses accumulator 2·Σ c[j]·(x[m-16+j] + x[m-17-j]). The second uses accumulator 65536·x[m-16]. Inputs must be at least two cycles apart.
- R6: The output is floor((acc + 2^(s-1)) / 2^s) with s = 16 - rnd, where `rnd` is an unsigned 0..7. A nonzero `rnd` therefore scales the result by 2^rnd.
- R7: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R8: With `fmt` = 1, bit 15 of the two's-complement result is inverted, which gives offset binary. With `fmt` = 0 the result is output unchanged.
- R9: Mode bit 1 = 0 takes samples from `a_data`; mode bit 1 = 1 takes them from `b_data`. The unselected bus has no effect.
- R10: No output is produced on a cycle that follows neither an accepted sample nor the first half of an interpolation pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept strobe for the selected input sample |
| a_data | input | 16 | Input bus A, signed |
| b_data | input | 16 | Input bus B, signed |
| mode | input | 2 | Bit 0: 1 = interpolate, 0 = decimate; bit 1: 1 = bus B |
| sync | input | 1 | Forces an output for this sample in decimation |
| rnd | input | 3 | Rounding position and gain select |
| fmt | input | 1 | 1 = offset binary output |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Filtered output sample |

## Verification
The properties assume that in interpolation a new sample never arrives on the cycle right after an accepted one, because that cycle carries the second output of the pair. The bench keeps to this. Every interpolation drive is followed by a cycle with the strobe low, and decimation samples are sent back to back, which covers the fastest legal rate. Mode changes happen only between samples.

// File: rtl/hb_filter.sv
module hb_filter #(
  parameter int W  = 16,
  parameter int FB = 16,
  parameter int AW = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] a_data,
  input  logic signed [W-1:0] b_data,
  input  logic [1:0]          mode,
  input  logic                sync,
  input  logic [2:0]          rnd,
  input  logic                fmt,
  output logic                out_valid,
  output logic [W-1:0]        out_data
);
  localparam int NT = 67;
  localparam int CT = (NT - 1) / 2;
  localparam int NP = (CT + 1) / 2;
  localparam int IC = (CT - 1) / 2;

  function automatic logic signed [15:0] coef(input int j);
    case (j)
      0:  coef = 16'sd20750;
      1:  coef = -16'sd6850;
      2:  coef = 16'sd4000;
      3:  coef = -16'sd2700;
      4:  coef = 16'sd1950;
      5:  coef = -16'sd1450;
      6:  coef = 16'sd1080;
      7:  coef = -16'sd800;
      8:  coef = 16'sd590;
      9:  coef = -16'sd430;
      10: coef = 16'sd300;
      11: coef = -16'sd205;
      12: coef = 16'sd135;
      13: coef = -16'sd85;
      14: coef = 16'sd50;
      15: coef = -16'sd26;
      16: coef = 16'sd10;
      default: coef = 16'sd0;
    endcase
  endfunction

  function automatic logic [W-1:0] finish(input logic signed [AW-1:0] acc,
                                          input logic [2:0] r, input logic f);
    logic signed [AW-1:0] half, hi, lo, t;
    int s;
    s = FB - int'(r);
    half = '0;
    half[s-1] = 1'b1;
    hi = '0;
    hi[W-2:0] = '1;
    lo = '1;
    lo[W-2:0] = '0;
    t = (acc + half) >>> s;
    if (t > hi) t = hi;
    else if (t < lo) t = lo;
    finish = t[W-1:0] ^ {f, {(W-1){1'b0}}};
  endfunction

  logic signed [W-1:0] sel;
  logic signed [W-1:0] dl [NT-1];
  logic signed [W-1:0] w  [NT];
  logic signed [AW-1:0] acc_d, acc_a, acc_b;
  logic ph, pend, emit;
  logic [W-1:0] hold;

  assign sel  = mode[1] ? b_data : a_data;
  assign emit = mode[0] | sync | ~ph;

  always_comb begin
    w[0] = sel;
    for (int k = 1; k < NT; k++) w[k] = dl[k-1];
  end

  always_comb begin
    acc_d = AW'(w[CT]) <<< (FB - 1);
    acc_a = '0;
    for (int j = 0; j < NP; j++) begin
      acc_d += AW'(coef(j)) * (AW'(w[CT-1-2*j]) + AW'(w[CT+1+2*j]));
      acc_a += AW'(coef(j)) * (AW'(w[IC-j]) + AW'(w[IC+1+j]));
    end
    acc_a = acc_a <<< 1;
    acc_b = AW'(w[IC]) <<< FB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      ph        <= 1'b0;
      pend      <= 1'b0;
      hold      <= '0;
      for (int k = 0; k < NT-1; k++) dl[k] <= '0;
    end else begin
      pend      <= in_valid & mode[0];
      out_valid <= (in_valid & emit) | pend;
      if (in_valid && emit)
        out_data <= finish(mode[0] ? acc_a : acc_d, rnd, fmt);
      else if (pend)
        out_data <= hold;
      if (in_valid) begin
        dl[0] <= sel;
        for (int k = 1; k < NT-1; k++) dl[k] <= dl[k-1];
        if (!mode[0]) ph <= emit;
        hold <= finish(acc_b, rnd, fmt);
      end
    end
  end
endmodule

module hb_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [1:0] mode,
  input logic       sync,
  input logic       out_valid
);
  p_interp_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[0]) |=> !in_valid);

  p_interp_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[0]) |=> out_valid ##1 out_valid);

  p_sync_emits_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode[0] && sync) |=> out_valid);

  p_dec_alternate_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode[0] && !sync && out_valid && $past(in_valid && !mode[0]))
      |=> !out_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(in_valid && mode[0])) |=> !out_valid);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind hb_filter hb_filter_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
  .sync(sync), .out_valid(out_valid)
);

// File: tb/hb_filter_bench.sv
`timescale 1ns/1ps
module hb_filter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] a_data = '0;
  logic signed [15:0] b_data = '0;
  logic [1:0] mode = 2'b00;
  logic sync = 1'b0;
  logic [2:0] rnd = 3'd0;
  logic fmt = 1'b0;
  logic out_valid;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hb_filter u_hb_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_data(a_data), .b_data(b_data),
    .mode(mode), .sync(sync), .rnd(rnd), .fmt(fmt),
    .out_valid(out_valid), .out_data(out_data)
  );

  int cf [17] = '{20750, -6850, 4000, -2700, 1950, -1450, 1080, -800, 590,
                  -430, 300, -205, 135, -85, 50, -26, 10};
  longint hist [67];
  bit ph_m = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fin(longint acc, int r, bit f);
    longint t;
    logic [15:0] v;
    int s;
    s = 16 - r;
    t = (acc + (longint'(1) << (s - 1))) >>> s;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    v = t[15:0];
    if (f) v[15] = ~v[15];
    return v;
  endfunction

  function automatic longint acc_dec();
    longint a;
    a = hist[33] * 32768;
    for (int j = 0; j < 17; j++) a += longint'(cf[j]) * (hist[32-2*j] + hist[34+2*j]);
    return a;
  endfunction

  function automatic longint acc_int_a();
    longint a;
    a = 0;
    for (int j = 0; j < 17; j++) a += longint'(cf[j]) * (hist[16-j] + hist[17+j]);
    return 2 * a;
  endfunction

  task automatic push(logic signed [15:0] a, logic signed [15:0] b, bit sy, string req);
    logic signed [15:0] smp;
    logic [15:0] ea, eb;
    bit em;
    smp = mode[1] ? b : a;
    for (int k = 66; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(smp);
    a_data = a; b_data = b; sync = sy; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sync = 1'b0;
    if (mode[0]) begin
      ea = fin(acc_int_a(), rnd, fmt);
      eb = fin(hist[16] * 65536, rnd, fmt);
      check(out_valid === 1'b1 && out_data === ea, req, out_data, ea);
      @(negedge clk);
      check(out_valid === 1'b1 && out_data === eb, req, out_data, eb);
    end else begin
      em = sy | !ph_m;
      ph_m = em;
      check(out_valid === em, {req, " valid"}, out_valid, em);
      if (em) begin
        ea = fin(acc_dec(), rnd, fmt);
        check(out_data === ea, req, out_data, ea);
      end
    end
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0, "R1 valid", out_valid, 0);
    check(out_data === 16'd0, "R1 data", out_data, 0);
  endtask

  task automatic t_decimate();
    mode = 2'b00; rnd = 3'd0; fmt = 1'b0;
    push(16'sd1000, 16'sd0, 1'b1, "R2");
    for (int i = 0; i < 40; i++)
      push(16'(i * 731 - 12000), 16'sd0, 1'b0, "R3");
    for (int i = 0; i < 20; i++)
      push(16'(((i % 3) == 0) ? 16000 : -9000), 16'sd0, 1'b0, "R2");
  endtask

  task automatic t_sync();
    mode = 2'b00;
    push(16'sd500, 16'sd0, 1'b0, "R3");
    if (!ph_m) push(16'sd501, 16'sd0, 1'b0, "R3");
    push(16'sd777, 16'sd0, 1'b1, "R4");
    push(-16'sd777, 16'sd0, 1'b0, "R4");
    push(16'sd123, 16'sd0, 1'b1, "R4");
    push(16'sd124, 16'sd0, 1'b1, "R4");
  endtask

  task automatic t_interp();
    mode = 2'b01; rnd = 3'd0; fmt = 1'b0;
    for (int i = 0; i < 40; i++)
      push(16'((i * 1999) % 30000 - 15000), 16'sd0, 1'b0, "R5");
  endtask

  task automatic t_round();
    mode = 2'b00;
    for (int r = 0; r < 8; r++) begin
      rnd = 3'(r);
      push(16'(r * 37 - 101), 16'sd0, 1'b0, "R6");
      push(16'(r * 53 + 7), 16'sd0, 1'b0, "R6");
    end
    mode = 2'b01;
    for (int r = 0; r < 8; r++) begin
      rnd = 3'(r);
      push(16'(r * 29 - 61), 16'sd0, 1'b0, "R6");
    end
    rnd = 3'd0;
  endtask

  task automatic t_saturate();
    mode = 2'b01; rnd = 3'd2;
    for (int i = 0; i < 18; i++)
      push(((i % 2) == 0) ? 16'sd20000 : -16'sd20000, 16'sd0, 1'b0, "R7");
    rnd = 3'd7;
    push(16'sd30000, 16'sd0, 1'b0, "R7");
    rnd = 3'd0;
  endtask

  task automatic t_format();
    fmt = 1'b1;
    mode = 2'b00;
    for (int i = 0; i < 8; i++) push(16'(i * 2500 - 9000), 16'sd0, 1'b0, "R8");
    mode = 2'b01;
    for (int i = 0; i < 4; i++) push(16'(-i * 3100), 16'sd0, 1'b0, "R8");
    fmt = 1'b0;
  endtask

  task automatic t_stream_b();
    mode = 2'b10;
    for (int i = 0; i < 12; i++) push(16'sh7fff, 16'(i * 900 - 4000), 1'b0, "R9");
    mode = 2'b11;
    for (int i = 0; i < 6; i++) push(-16'sh8000, 16'(i * 1500), 1'b0, "R9");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R10", out_valid, 0);
    end
  endtask

  initial begin
    for (int k = 0; k < 67; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decimate();
    t_sync();
    t_idle();
    t_interp();
    t_idle();
    t_round();
    t_saturate();
    t_format();
    t_stream_b();
    t_idle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule